// File: doc/BRIEF.md
# Configurable Four-Element Logic Cluster

This block is one programmable logic tile of an island-style fabric. It holds four logic elements. Each element has a 4-input lookup table whose result feeds a D flip-flop. A per-element mode bit then decides whether the element output is the registered value or the lookup result directly. A full crossbar chooses the source of each of the sixteen lookup inputs. The sources are the ten cluster inputs, the four element outputs fed back, and a constant zero. Element output k appears unchanged on cluster output k.

All behaviour comes from a 132-bit configuration image that is loaded serially. The chain is grouped per element, starting with element 0. Each element group holds 33 bits: 16 truth-table bits at the low end, then four 4-bit input selects, then the mode bit. Chain bit 0 is the bit nearest the serial output. While the chain is shifting, the cluster outputs carry no meaning. Combinational feedback that forms a loop is an illegal configuration. Acyclic combinational chains through several elements settle within the same cycle, in any element order.

Top module: `lut_cluster`

## Requirements
- R1: Each element's lookup result is bit {i3,i2,i1,i0} of its 16-bit truth table, where i0 is the least significant index bit. The truth table sits at chain bits e*33 to e*33+15, with table bit n at e*33+n.
- R2: The select for input j of element e is the 4-bit field at chain bits e*33+16+4j upward. Codes 0 to 9 pick cluster inputs 0 to 9, codes 10 to 13 pick element outputs 0 to 3, and codes 14 and 15 supply constant 0.
- R3: Chain bit e*33+32 is the mode of element e. A 1 drives cluster output e from the element flip-flop, and a 0 drives it from the lookup result in the same cycle.
- R4: On every rising clock edge with reset low, each flip-flop takes its element's current lookup result. All four flip-flops share the cluster clock.
- R5: A synchronous active-high reset clears all four flip-flops at the next edge and leaves the configuration untouched.
- R6: While cfg_en is high, each edge shifts the chain one place toward bit 0 and loads cfg_di into bit 131. cfg_do always shows chain bit 0, so a loaded image leaves the chain in shift order, bit 0 first.
- R7: While cfg_en is low, the configuration holds and cfg_di has no effect.
- R8: An acyclic combinational path through several elements settles in the same cycle, whatever the element numbering along the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cluster clock for flip-flops and chain |
| rst | input | 1 | Synchronous active-high flip-flop clear |
| cfg_en | input | 1 | Shift enable of the configuration chain |
| cfg_di | input | 1 | Serial configuration data into chain bit 131 |
| cfg_do | output | 1 | Serial configuration data from chain bit 0 |
| cl_in | input | 10 | General cluster inputs |
| cl_out | output | 4 | Element outputs, bit k from element k |

## Verification
The assertions assume that no loaded configuration contains a combinational loop. They also assume that the flip-flop and chain properties are checked only once reset has released them. The stimulus uses two images. One has a single registered element fed back into its own input or from another element. The other has a three-element combinational chain running from the highest element down. Neither image closes a loop through lookup results. Output comparisons are paused while the chain shifts. After each load, the registered bits are masked until a reset cycle has given them a known value. During normal cycles cfg_di toggles while cfg_en stays low, so the image is not disturbed.

// File: rtl/lut_cluster.sv
`timescale 1ns/1ps
module lut_cluster #(
  parameter int N_ELEM = 4,
  parameter int N_IN   = 10,
  parameter int K      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic              cfg_di,
  output logic              cfg_do,
  input  logic [N_IN-1:0]   cl_in,
  output logic [N_ELEM-1:0] cl_out
);
  localparam int SW   = $clog2(N_IN + N_ELEM + 1);
  localparam int NSRC = 1 << SW;
  localparam int TT   = 1 << K;
  localparam int EW   = TT + K * SW + 1;
  localparam int CW   = N_ELEM * EW;

  logic [CW-1:0]     cfg;
  logic [N_ELEM-1:0] q, lut, fb;

  always_ff @(posedge clk)
    if (cfg_en) cfg <= {cfg_di, cfg[CW-1:1]};

  always_ff @(posedge clk)
    q <= rst ? '0 : lut;

  always_comb begin
    logic [NSRC-1:0] src;
    logic [K-1:0]    idx;
    logic [TT-1:0]   tt;
    logic [SW-1:0]   s;
    src = '0; idx = '0; tt = '0; s = '0; lut = '0; fb = '0;
    for (int e = 0; e < N_ELEM; e++)
      fb[e] = cfg[e*EW + TT + K*SW] & q[e];
    for (int p = 0; p < N_ELEM; p++) begin
      src = '0;
      src[N_IN-1:0] = cl_in;
      src[N_IN +: N_ELEM] = fb;
      for (int e = 0; e < N_ELEM; e++) begin
        tt = cfg[e*EW +: TT];
        for (int j = 0; j < K; j++) begin
          s = cfg[e*EW + TT + j*SW +: SW];
          idx[j] = src[s];
        end
        lut[e] = tt[idx];
      end
      for (int e = 0; e < N_ELEM; e++)
        fb[e] = cfg[e*EW + TT + K*SW] ? q[e] : lut[e];
    end
  end

  assign cl_out = fb;
  assign cfg_do = cfg[0];
endmodule

// File: rtl/lut_cluster_chk.sv
`timescale 1ns/1ps
module lut_cluster_chk #(
  parameter int N_ELEM = 4,
  parameter int CW     = 132
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en,
  input logic              cfg_do,
  input logic [CW-1:0]     cfg,
  input logic [N_ELEM-1:0] q,
  input logic [N_ELEM-1:0] lut
);
  // R5
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> q == '0);

  // R6
  shift_out_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_do == $past(cfg[1]));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg));

  // R4
  ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q == $past(lut));
endmodule

bind lut_cluster lut_cluster_chk #(.N_ELEM(N_ELEM), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_do(cfg_do),
  .cfg(cfg), .q(q), .lut(lut)
);

// File: tb/test_lut_cluster.sv
`timescale 1ns/1ps
module test_lut_cluster;
  localparam int CWB = 132;

  logic       clk = 0, rst = 1, cfg_en = 0, cfg_di = 0;
  logic       cfg_do;
  logic [9:0] cl_in = '0;
  logic [3:0] cl_out;

  lut_cluster i_lut_cluster (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_di(cfg_di),
    .cfg_do(cfg_do), .cl_in(cl_in), .cl_out(cl_out)
  );

  always #10 clk = ~clk;

  typedef struct { logic [3:0] exp; logic [3:0] mask; string tag; } item_t;
  item_t sbq[$];
  item_t it;
  int checks = 0, errors = 0;
  bit done = 0;
  bit use_b = 0;
  logic qm = 0;

  logic [15:0] tt_b [4];
  logic [3:0]  sel_b [4][4];
  logic        md_b [4];
  logic [CWB-1:0] img_a, img_b;

  function automatic logic [CWB-1:0] mkcfg();
    logic [CWB-1:0] v = '0;
    for (int e = 0; e < 4; e++) begin
      v[e*33 +: 16] = tt_b[e];
      for (int j = 0; j < 4; j++) v[e*33 + 16 + j*4 +: 4] = sel_b[e][j];
      v[e*33 + 32] = md_b[e];
    end
    return v;
  endfunction

  always @(negedge clk)
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      checks++;
      if ((cl_out & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: cl_out=%b expected %b (mask %b)", it.tag, cl_out, it.exp, it.mask);
      end
    end

  task automatic load(input logic [CWB-1:0] v, input logic [CWB-1:0] prev, input bit chk);
    for (int i = 0; i < CWB; i++) begin
      @(posedge clk); #5;
      cfg_en = 1; cfg_di = v[i];
      #4;
      if (chk) begin
        checks++;
        if (cfg_do !== prev[i]) begin
          errors++;
          $display("FAIL R6: cfg_do bit %0d = %b expected %b", i, cfg_do, prev[i]);
        end
      end
    end
    @(posedge clk); #5;
    cfg_en = 0;
  endtask

  task automatic step(input logic [9:0] vin, input logic rv, input logic [3:0] mask, input string tag);
    item_t x;
    logic o1, o2, o3;
    @(posedge clk); #5;
    cl_in = vin; rst = rv; cfg_di = ~cfg_di;
    if (!use_b) begin
      x.exp = {qm, vin[8] & ~vin[9], ^vin[7:4], &vin[3:0]};
      x.mask = mask; x.tag = tag;
      sbq.push_back(x);
      qm = rv ? 1'b0 : &vin[3:0];
    end else begin
      o3 = ~vin[0]; o2 = o3 & vin[1]; o1 = o2 ^ vin[2];
      x.exp = {o3, o2, o1, qm};
      x.mask = mask; x.tag = tag;
      sbq.push_back(x);
      qm = rv ? 1'b0 : ~qm;
    end
  endtask

  initial begin
    logic [9:0] lf = 10'h2B5;
    // image A: AND, XOR, index order with constants, registered feedback
    tt_b[0] = 16'h8000; sel_b[0] = '{4'd0, 4'd1, 4'd2, 4'd3}; md_b[0] = 0;
    tt_b[1] = 16'h6996; sel_b[1] = '{4'd4, 4'd5, 4'd6, 4'd7}; md_b[1] = 0;
    tt_b[2] = 16'h0002; sel_b[2] = '{4'd8, 4'd9, 4'd14, 4'd15}; md_b[2] = 0;
    tt_b[3] = 16'hAAAA; sel_b[3] = '{4'd10, 4'd14, 4'd15, 4'd14}; md_b[3] = 1;
    img_a = mkcfg();
    // image B: chain 3 -> 2 -> 1, element 0 toggles on its own output
    tt_b[3] = 16'h5555; sel_b[3] = '{4'd0, 4'd14, 4'd14, 4'd14}; md_b[3] = 0;
    tt_b[2] = 16'h8888; sel_b[2] = '{4'd13, 4'd1, 4'd14, 4'd14}; md_b[2] = 0;
    tt_b[1] = 16'h6666; sel_b[1] = '{4'd12, 4'd2, 4'd15, 4'd15}; md_b[1] = 0;
    tt_b[0] = 16'h5555; sel_b[0] = '{4'd10, 4'd14, 4'd14, 4'd14}; md_b[0] = 1;
    img_b = mkcfg();

    repeat (2) @(posedge clk);
    load(img_a, '0, 0);
    step(10'h00F, 1, 4'b0111, "R1 R2 R3 comb after load");
    step(10'h00F, 0, 4'b1111, "R5 reset state");
    step(10'h3FF, 0, 4'b1111, "R1 R4 AND registered");
    step(10'h100, 0, 4'b1111, "R1 R2 index order");
    step(10'h0F0, 0, 4'b1111, "R2 R7 xor inputs");
    step(10'h0A5, 0, 4'b1111, "R3 R4 feedback");
    step(10'h200, 0, 4'b1111, "R2 const codes");
    step(10'h30F, 0, 4'b1111, "R1 R4");
    step(10'h1FE, 0, 4'b1111, "R1 R3");
    for (int n = 0; n < 24; n++) begin
      lf = {lf[8:0], lf[9] ^ lf[6]};
      step(lf, 0, 4'b1111, "R1 R2 R4 sweep");
    end
    step(10'h3FF, 1, 4'b1111, "R5 assert reset");
    step(10'h3FF, 0, 4'b1111, "R5 flops cleared, config kept");
    step(10'h3FF, 0, 4'b1111, "R4 capture after reset");
    step(10'h000, 0, 4'b1111, "R4 R7");

    wait (sbq.size() == 0);
    load(img_b, img_a, 1);
    use_b = 1;
    step(10'h007, 1, 4'b1110, "R8 chain after load");
    step(10'h006, 0, 4'b1111, "R8 R5 toggle from zero");
    step(10'h002, 0, 4'b1111, "R8 chain");
    step(10'h004, 0, 4'b1111, "R8 R2 element codes");
    step(10'h001, 0, 4'b1111, "R8 R3");
    step(10'h3F8, 0, 4'b1111, "R8 R4 toggle");
    for (int n = 0; n < 16; n++) step(10'(n * 37), 0, 4'b1111, "R8 R4 sweep");
    step(10'h000, 1, 4'b1111, "R5 reset mid toggle");
    step(10'h000, 0, 4'b1111, "R5 toggle restarts");

    wait (sbq.size() == 0);
    @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule